// File: doc/BRIEF.md
# Program-Counter Sampling Debug Window

This block is a per-core window of external debug registers on a 32-bit APB-style slave port. A debugger, or a panic handler that has found a core stuck with interrupts masked, polls it to learn where that core is executing. On the core side it sees the live program counter, the context ID, the virtual machine ID, the security state, the exception level, the register width, and a set of status inputs: power domain up, double lock, halted in debug state, and profiling prohibited.

Reading the low PC sample word returns the live PC and, in the same access, freezes the context ID, the virtualization context word and the upper PC half into sample registers. Later reads of those registers therefore describe the same instant. A status word, an OS lock that software must clear before sampling, and two identification words complete the window. Parameters pick the sampling support level, the PC-offset code and the widths.

Top module: `pcs_prof_window`

## Requirements
- R1: After reset the OS lock is set and the context, virtualization and upper-PC sample registers all hold 0.
- R2: Offset 0x314 reads bit 0 = core power up, bit 5 = OS lock, bit 6 = double lock, all other bits 0, and it can be read in every state.
- R3: When access is open, a read of offset 0x0A0 returns PC[31:0]. The same access latches the context ID (offset 0x0A4), the virtualization word (0x0A8) and PC[63:32] (0x0AC). Later reads of those offsets return that snapshot, not live values.
- R4: When access is open and the core is halted or profiling is prohibited, a read of 0x0A0 returns 0xFFFFFFFF and leaves the three sample registers unchanged.
- R5: The virtualization word has bit 31 = non-secure, bit 30 = running at EL2, bit 29 = running at EL3, bit 28 = 64-bit width, bits 7:0 = VMID, and 0 elsewhere. The exception level input is 2 bits, with 2 = EL2 and 3 = EL3.
- R6: Access is closed when power is down, the double lock is set or the OS lock is set. While closed, reads of 0x0A0 to 0x0AC return 0 and capture nothing.
- R7: A write to 0x300 sets the OS lock to write-data bit 0, so writing 0 opens access. Reads of 0x300 return 0.
- R8: Offset 0xFC8 bits 3:0 read the sampling mode (3 = full, 2 = PC and context only) and offset 0xFC4 bits 3:0 read the PC-offset code. In mode 2, offset 0x0A8 reads 0 and is never loaded. In any mode other than 2 or 3 all sample offsets read 0.
- R9: Writes to the sample, status and ID offsets have no effect, and a write to 0x0A0 captures nothing.
- R10: Every access completes in one cycle: ready is always 1 and the error response is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| core_pc | input | PC_W | Live program counter |
| core_ctxid | input | 32 | Live context ID |
| core_vmid | input | VMID_W | Live virtual machine ID |
| core_nonsec | input | 1 | Core is in non-secure state |
| core_el | input | 2 | Current exception level |
| core_aa64 | input | 1 | Core runs in 64-bit state |
| core_pwr_up | input | 1 | Core power domain is up |
| core_dlock | input | 1 | Double lock is set |
| core_halted | input | 1 | Core is in debug state |
| prof_prohibit | input | 1 | Sampling is not permitted |

## Verification
Read data is combinational in the access phase, so the bench samples prdata one nanosecond after the negative edge that raises penable, before the closing rising edge. Snapshot and OS lock changes take effect at that closing edge. The bench therefore checks them only in a later transaction, which always starts at least one full cycle after the capturing one. Core inputs are changed between transactions, so a read of a sample register shows whether it holds the snapshot or the live value.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   localparam logic [11:0] OFS_PC_LO  = 12'h0A0;
   localparam logic [11:0] OFS_CTX    = 12'h0A4;
   localparam logic [11:0] OFS_VIRT   = 12'h0A8;
   localparam logic [11:0] OFS_PC_HI  = 12'h0AC;
   localparam logic [11:0] OFS_OSLOCK = 12'h300;
   localparam logic [11:0] OFS_STATUS = 12'h314;
   localparam logic [11:0] OFS_IDENT1 = 12'hFC4;
   localparam logic [11:0] OFS_IDENT0 = 12'hFC8;

   localparam logic [3:0] MODE_FULL  = 4'h3;
   localparam logic [3:0] MODE_PCCTX = 4'h2;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_PC_LO, SEL_CTX, SEL_VIRT, SEL_PC_HI,
      SEL_OSLOCK, SEL_STATUS, SEL_IDENT1, SEL_IDENT0
   } reg_sel_e;
endpackage

// File: rtl/pcs_regdec.sv
module pcs_regdec
   import pcs_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   always_comb begin
      unique case (addr)
         ADDR_W'(OFS_PC_LO):  sel = SEL_PC_LO;
         ADDR_W'(OFS_CTX):    sel = SEL_CTX;
         ADDR_W'(OFS_VIRT):   sel = SEL_VIRT;
         ADDR_W'(OFS_PC_HI):  sel = SEL_PC_HI;
         ADDR_W'(OFS_OSLOCK): sel = SEL_OSLOCK;
         ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
         ADDR_W'(OFS_IDENT1): sel = SEL_IDENT1;
         ADDR_W'(OFS_IDENT0): sel = SEL_IDENT0;
         default:             sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/pcs_virt_pack.sv
module pcs_virt_pack #(
   parameter int VMID_W = 8
) (
   input  logic              nonsec,
   input  logic [1:0]        el,
   input  logic              aa64,
   input  logic [VMID_W-1:0] vmid,
   output logic [31:0]       word
);
   localparam int PAD_W = 8 - VMID_W;
   logic [7:0] vmid8;

   generate
      if (PAD_W > 0) begin : g_pad
         assign vmid8 = {{PAD_W{1'b0}}, vmid};
      end else begin : g_nopad
         assign vmid8 = vmid;
      end
   endgenerate

   assign word = {nonsec, (el == 2'd2), (el == 2'd3), aa64, 20'd0, vmid8};
endmodule

// File: rtl/pcs_snapshot.sv
module pcs_snapshot #(
   parameter bit HAS_VIRT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cap_en,
   input  logic [31:0] ctx_in,
   input  logic [31:0] virt_in,
   input  logic [31:0] pchi_in,
   output logic [31:0] ctx_q,
   output logic [31:0] virt_q,
   output logic [31:0] pchi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_q  <= '0;
         pchi_q <= '0;
      end else if (cap_en) begin
         ctx_q  <= ctx_in;
         pchi_q <= pchi_in;
      end
   end

   generate
      if (HAS_VIRT) begin : g_virt
         logic [31:0] virt_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      virt_r <= '0;
            else if (cap_en) virt_r <= virt_in;
         end
         assign virt_q = virt_r;
      end else begin : g_novirt
         logic unused_virt;
         assign unused_virt = ^virt_in;
         assign virt_q      = '0;
      end
   endgenerate
endmodule

// File: rtl/pcs_prof_window.sv
module pcs_prof_window
   import pcs_pkg::*;
#(
   parameter int         ADDR_W      = 12,
   parameter int         PC_W        = 64,
   parameter int         VMID_W      = 8,
   parameter logic [3:0] SAMPLE_MODE = 4'h3,
   parameter logic [3:0] PC_OFS_CODE = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [PC_W-1:0]   core_pc,
   input  logic [31:0]       core_ctxid,
   input  logic [VMID_W-1:0] core_vmid,
   input  logic              core_nonsec,
   input  logic [1:0]        core_el,
   input  logic              core_aa64,
   input  logic              core_pwr_up,
   input  logic              core_dlock,
   input  logic              core_halted,
   input  logic              prof_prohibit
);
   localparam bit HAS_SAMP = (SAMPLE_MODE == MODE_FULL) || (SAMPLE_MODE == MODE_PCCTX);
   localparam bit HAS_VIRT = (SAMPLE_MODE == MODE_FULL);
   localparam int HI_W     = PC_W - 32;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("pcs_prof_window: ADDR_W must be at least 12");
      end
      if (PC_W < 33 || PC_W > 64) begin : g_bad_pc
         $error("pcs_prof_window: PC_W must lie in 33..64");
      end
      if (VMID_W < 1 || VMID_W > 8) begin : g_bad_vmid
         $error("pcs_prof_window: VMID_W must lie in 1..8");
      end
   endgenerate

   reg_sel_e    sel;
   logic        rd_acc, wr_acc;
   logic        os_lock_q;
   logic        open_acc, blocked, cap_en;
   logic [31:0] virt_live, pchi_live;
   logic [31:0] snap_ctx, snap_virt, snap_pchi;
   logic        unused_wdata;

   assign rd_acc = psel & penable & ~pwrite;
   assign wr_acc = psel & penable & pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign unused_wdata = ^pwdata[31:1];

   pcs_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (paddr),
      .sel  (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             os_lock_q <= 1'b1;
      else if (wr_acc && sel == SEL_OSLOCK)   os_lock_q <= pwdata[0];
   end

   assign open_acc = HAS_SAMP & core_pwr_up & ~core_dlock & ~os_lock_q;
   assign blocked  = core_halted | prof_prohibit;
   assign cap_en   = rd_acc & (sel == SEL_PC_LO) & open_acc & ~blocked;

   generate
      if (HI_W < 32) begin : g_hi_pad
         assign pchi_live = {{(32 - HI_W){1'b0}}, core_pc[PC_W-1:32]};
      end else begin : g_hi_full
         assign pchi_live = core_pc[PC_W-1:32];
      end
   endgenerate

   pcs_virt_pack #(.VMID_W(VMID_W)) u_pack (
      .nonsec (core_nonsec),
      .el     (core_el),
      .aa64   (core_aa64),
      .vmid   (core_vmid),
      .word   (virt_live)
   );

   pcs_snapshot #(.HAS_VIRT(HAS_VIRT)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .ctx_in  (core_ctxid),
      .virt_in (virt_live),
      .pchi_in (pchi_live),
      .ctx_q   (snap_ctx),
      .virt_q  (snap_virt),
      .pchi_q  (snap_pchi)
   );

   always_comb begin
      prdata = '0;
      if (rd_acc) begin
         unique case (sel)
            SEL_PC_LO:  prdata = !open_acc ? 32'd0 : (blocked ? 32'hFFFF_FFFF : core_pc[31:0]);
            SEL_CTX:    prdata = open_acc ? snap_ctx  : 32'd0;
            SEL_VIRT:   prdata = open_acc ? snap_virt : 32'd0;
            SEL_PC_HI:  prdata = open_acc ? snap_pchi : 32'd0;
            SEL_STATUS: prdata = {25'd0, core_dlock, os_lock_q, 4'd0, core_pwr_up};
            SEL_IDENT1: prdata = {28'd0, PC_OFS_CODE};
            SEL_IDENT0: prdata = {28'd0, SAMPLE_MODE};
            default:    prdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pcs_prof_window_chk.sv
module pcs_prof_window_chk
   import pcs_pkg::*;
#(
   parameter int         ADDR_W      = 12,
   parameter logic [3:0] SAMPLE_MODE = 4'h3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [31:0]       prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [31:0]       core_ctxid,
   input logic              core_pwr_up,
   input logic              core_dlock,
   input logic              core_halted,
   input logic              prof_prohibit,
   input logic              os_lock,
   input logic [31:0]       snap_ctx
);
   localparam bit SAMP_ON = (SAMPLE_MODE == MODE_FULL) || (SAMPLE_MODE == MODE_PCCTX);

   logic rd, wr, acc_ok, halt_any;
   assign rd       = psel && penable && !pwrite;
   assign wr       = psel && penable && pwrite;
   assign acc_ok   = SAMP_ON && core_pwr_up && !core_dlock && !os_lock;
   assign halt_any = core_halted || prof_prohibit;

   // R3
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && paddr == ADDR_W'(OFS_PC_LO) && acc_ok && !halt_any) |=> (snap_ctx == $past(core_ctxid)));

   // R4
   prohibited_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && paddr == ADDR_W'(OFS_PC_LO) && acc_ok && halt_any) |-> (prdata == 32'hFFFF_FFFF));

   // R4
   prohibited_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && paddr == ADDR_W'(OFS_PC_LO) && acc_ok && halt_any) |=> $stable(snap_ctx));

   // R6
   closed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && paddr == ADDR_W'(OFS_PC_LO) && !acc_ok) |-> (prdata == 32'd0));

   // R6
   closed_nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_ok |=> $stable(snap_ctx));

   // R2
   status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && paddr == ADDR_W'(OFS_STATUS)) |-> (prdata[0] == core_pwr_up && prdata[6] == core_dlock && prdata[5] == os_lock));

   // R7
   oslock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'(OFS_OSLOCK)) |=> (os_lock == $past(pwdata[0])));

   // R10
   no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pready && !pslverr);
endmodule

bind pcs_prof_window pcs_prof_window_chk #(
   .ADDR_W      (ADDR_W),
   .SAMPLE_MODE (SAMPLE_MODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .psel          (psel),
   .penable       (penable),
   .pwrite        (pwrite),
   .paddr         (paddr),
   .pwdata        (pwdata),
   .prdata        (prdata),
   .pready        (pready),
   .pslverr       (pslverr),
   .core_ctxid    (core_ctxid),
   .core_pwr_up   (core_pwr_up),
   .core_dlock    (core_dlock),
   .core_halted   (core_halted),
   .prof_prohibit (prof_prohibit),
   .os_lock       (os_lock_q),
   .snap_ctx      (snap_ctx)
);

// File: tb/pcs_prof_window_bench.sv
module pcs_prof_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata, prdata_m2;
   logic        pready, pslverr, pready_m2, pslverr_m2;
   logic [63:0] core_pc = '0;
   logic [31:0] core_ctxid = '0;
   logic [7:0]  core_vmid = '0;
   logic        core_nonsec = 1'b0, core_aa64 = 1'b0;
   logic [1:0]  core_el = 2'd1;
   logic        core_pwr_up = 1'b1, core_dlock = 1'b0, core_halted = 1'b0, prof_prohibit = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pcs_prof_window u_pcs_prof_window (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .core_pc(core_pc), .core_ctxid(core_ctxid), .core_vmid(core_vmid),
      .core_nonsec(core_nonsec), .core_el(core_el), .core_aa64(core_aa64),
      .core_pwr_up(core_pwr_up), .core_dlock(core_dlock), .core_halted(core_halted),
      .prof_prohibit(prof_prohibit)
   );

   pcs_prof_window #(.SAMPLE_MODE(4'h2)) u_pcs_prof_window_m2 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m2), .pready(pready_m2), .pslverr(pslverr_m2),
      .core_pc(core_pc), .core_ctxid(core_ctxid), .core_vmid(core_vmid),
      .core_nonsec(core_nonsec), .core_el(core_el), .core_aa64(core_aa64),
      .core_pwr_up(core_pwr_up), .core_dlock(core_dlock), .core_halted(core_halted),
      .prof_prohibit(prof_prohibit)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] d2);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1;
      d = prdata; d2 = prdata_m2;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d, d2;
      rd(12'h314, d, d2); chk("R1", "status after reset", d, 32'h21);
      rd(12'h0A0, d, d2); chk("R6", "pc read while os-locked", d, 32'h0);
      rd(12'hFC8, d, d2); chk("R8", "mode id", d, 32'h3);
      chk("R8", "mode id mode2", d2, 32'h2);
      rd(12'hFC4, d, d2); chk("R8", "offset code", d, 32'h0);
   endtask

   task automatic t_unlock();
      logic [31:0] d, d2;
      rd(12'h300, d, d2); chk("R7", "oslock reads zero", d, 32'h0);
      wr(12'h300, 32'h0);
      rd(12'h314, d, d2); chk("R7", "status after unlock", d, 32'h01);
      rd(12'h0A4, d, d2); chk("R1", "ctx reset value", d, 32'h0);
      rd(12'h0A8, d, d2); chk("R1", "virt reset value", d, 32'h0);
      rd(12'h0AC, d, d2); chk("R1", "pc-hi reset value", d, 32'h0);
   endtask

   task automatic t_capture();
      logic [31:0] d, d2;
      @(negedge clk);
      core_pc = 64'h1234_5678_9ABC_DEF1; core_ctxid = 32'hCAFE_0001;
      core_nonsec = 1'b1; core_el = 2'd2; core_aa64 = 1'b1; core_vmid = 8'h5A;
      rd(12'h0A0, d, d2); chk("R3", "pc low live", d, 32'h9ABC_DEF1);
      chk("R10", "ready", {31'd0, pready}, 32'h1);
      chk("R10", "no error", {31'd0, pslverr}, 32'h0);
      @(negedge clk);
      core_pc = 64'hAAAA_BBBB_CCCC_DDDC; core_ctxid = 32'h0BAD_F00D;
      core_nonsec = 1'b0; core_el = 2'd1; core_aa64 = 1'b0; core_vmid = 8'h11;
      rd(12'h0A4, d, d2); chk("R3", "ctx snapshot", d, 32'hCAFE_0001);
      chk("R3", "ctx snapshot mode2", d2, 32'hCAFE_0001);
      rd(12'h0A8, d, d2); chk("R5", "virt snapshot ns/el2/aa64", d, 32'hD000_005A);
      chk("R8", "virt absent in mode2", d2, 32'h0);
      rd(12'h0AC, d, d2); chk("R3", "pc high snapshot", d, 32'h1234_5678);
   endtask

   task automatic t_prohibit();
      logic [31:0] d, d2;
      @(negedge clk); core_halted = 1'b1;
      rd(12'h0A0, d, d2); chk("R4", "halted pc read", d, 32'hFFFF_FFFF);
      @(negedge clk); core_halted = 1'b0; prof_prohibit = 1'b1;
      rd(12'h0A0, d, d2); chk("R4", "prohibited pc read", d, 32'hFFFF_FFFF);
      @(negedge clk); prof_prohibit = 1'b0;
      rd(12'h0A4, d, d2); chk("R4", "ctx held after blocked reads", d, 32'hCAFE_0001);
      rd(12'h0AC, d, d2); chk("R4", "pc high held", d, 32'h1234_5678);
   endtask

   task automatic t_closed();
      logic [31:0] d, d2;
      @(negedge clk); core_dlock = 1'b1;
      rd(12'h314, d, d2); chk("R2", "status double lock", d, 32'h41);
      rd(12'h0A0, d, d2); chk("R6", "pc read double locked", d, 32'h0);
      rd(12'h0A4, d, d2); chk("R6", "ctx read double locked", d, 32'h0);
      @(negedge clk); core_dlock = 1'b0; core_pwr_up = 1'b0;
      rd(12'h314, d, d2); chk("R2", "status powered down", d, 32'h00);
      rd(12'h0A0, d, d2); chk("R6", "pc read powered down", d, 32'h0);
      @(negedge clk); core_pwr_up = 1'b1;
      rd(12'h0A4, d, d2); chk("R6", "no capture while closed", d, 32'hCAFE_0001);
   endtask

   task automatic t_ro_writes();
      logic [31:0] d, d2;
      wr(12'h0A4, 32'hFFFF_FFFF);
      wr(12'h314, 32'hFFFF_FFFF);
      wr(12'hFC8, 32'hFFFF_FFFF);
      wr(12'h0A0, 32'h0);
      rd(12'h0A4, d, d2); chk("R9", "ctx after writes", d, 32'hCAFE_0001);
      rd(12'h314, d, d2); chk("R9", "status after write", d, 32'h01);
      rd(12'hFC8, d, d2); chk("R9", "mode id after write", d, 32'h3);
   endtask

   task automatic t_secure_el3();
      logic [31:0] d, d2;
      @(negedge clk);
      core_pc = 64'h0000_0000_0000_1001; core_ctxid = 32'h0000_0042;
      core_nonsec = 1'b0; core_el = 2'd3; core_aa64 = 1'b0; core_vmid = 8'h03;
      rd(12'h0A0, d, d2); chk("R3", "thumb pc low", d, 32'h0000_1001);
      chk("R3", "thumb pc low mode2", d2, 32'h0000_1001);
      rd(12'h0A8, d, d2); chk("R5", "virt secure el3 32-bit", d, 32'h2000_0003);
      rd(12'h0AC, d, d2); chk("R3", "pc high zero", d, 32'h0);
      rd(12'h0A4, d, d2); chk("R3", "ctx mode2", d2, 32'h0000_0042);
   endtask

   task automatic t_relock();
      logic [31:0] d, d2;
      wr(12'h300, 32'h1);
      rd(12'h314, d, d2); chk("R7", "status relocked", d, 32'h21);
      rd(12'h0A0, d, d2); chk("R6", "pc read relocked", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unlock();
      t_capture();
      t_prohibit();
      t_closed();
      t_ro_writes();
      t_secure_el3();
      t_relock();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule